// File: doc/BRIEF.md
# SMBus Block Transfer Data Buffer

This block sits between a host controller's register interface and its bit-level bus engine and carries the payload of SMBus block transactions. Software loads or unloads the payload through one data-port register. A byte count register carries the length of the block. The bus engine moves bytes through a simple valid/take (write direction) or valid/ready (read direction) byte stream. The count byte always travels first on that stream.

There are two modes. The auxiliary register selects the mode, and the block latches it when a transfer starts. In buffer mode, software fills or drains a 32-entry buffer through the data port. An index walks that buffer by itself, and any read of the control register puts the index back to zero. The engine walks the buffer in the same order. In byte mode, the data port is a single holding byte. After every payload byte the stream stalls and a byte-done flag is raised. Software services the port and writes one to the flag, and that lets the next byte move. For reads in byte mode, software sets a last-byte bit in control before the final byte, so the engine is told to end the transfer on that byte.

Top module: `smbb_block_buf`

## Requirements
- R1: After reset, every register reads zero, and `eng_tx_valid`, `eng_rx_ready` and `eng_last` are low.
- R2: Register select codes are 0 status, 1 control, 2 byte count, 3 data port and 4 auxiliary. With auxiliary bit 1 set (buffer mode), each data-port read or write uses the buffer entry at the index and then advances the index by one.
- R3: A read of the control register returns the buffer index to zero.
- R4: A buffer-mode write is started with `eng_dir_rd` = 0 and count N. The stream offers the byte count first, then entries 0 to N-1 in order. Once the last byte is taken, status bit 1 (done) is set and status bit 0 (busy) clears.
- R5: In a buffer-mode read, the first accepted byte is written into the byte count register. The next N bytes go into entries 0 to N-1, and done is set after the Nth byte. A count of exactly 32 is valid.
- R6: A byte count of 0 or above 32 ends the transfer, sets status bit 4 (failed), and no further byte is offered or accepted. This applies to the count register when a write starts and to the first byte received on a read.
- R7: In byte mode (auxiliary bit 1 = 0), each payload byte sets status bit 7 (byte-done). Both stream directions then stall until software writes one to that bit. The count byte does not stall.
- R8: In byte mode the data port is one holding byte. A write to it supplies the next byte to send, and a read returns the byte most recently received.
- R9: In a byte-mode read with control bit 0 set, `eng_last` is high while a payload byte is awaited. The byte then received ends the transfer with done set.
- R10: Status bits 7, 4 and 1 are cleared by writing one to them. If the engine sets a bit in the same cycle that software clears it, the bit stays set.
- R11: In a buffer-mode read, `eng_last` is high only while the byte awaited is the Nth payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| eng_start | input | 1 | Engine starts a block transfer (ignored while busy) |
| eng_dir_rd | input | 1 | Direction at start: 1 read, 0 write |
| eng_tx_valid | output | 1 | A byte is offered to the engine |
| eng_tx_data | output | 8 | Offered byte |
| eng_tx_take | input | 1 | Engine consumes the offered byte |
| eng_rx_valid | input | 1 | Engine presents a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Block accepts the received byte |
| eng_last | output | 1 | Byte now awaited is the final one of the read |

## Verification
The one real collision is between a software write-one-to-clear on status and the engine setting the same bit in the same cycle. The bench drives the status write on exactly the clock edge where the engine takes the final byte of a buffer-mode write. It then reads status back and expects done still set. A plain clear that follows must then read zero. A behavioural queue model of the outgoing stream is compared on every clock edge where a byte is taken, so any reordering, stray byte or byte that leaks past a stall is caught.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
   typedef enum logic [2:0] {
      RA_STAT = 3'd0,
      RA_CTRL = 3'd1,
      RA_CNT  = 3'd2,
      RA_PORT = 3'd3,
      RA_AUX  = 3'd4
   } smbb_reg_e;

   localparam int unsigned ST_BUSY   = 0;
   localparam int unsigned ST_DONE   = 1;
   localparam int unsigned ST_FAIL   = 4;
   localparam int unsigned ST_BDONE  = 7;
   localparam int unsigned CTL_LAST  = 0;
   localparam int unsigned AUX_BUFEN = 1;
endpackage

// File: rtl/smbb_store.sv
module smbb_store #(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned DEPTH          = 32,
   parameter int unsigned IDX_W          = 5,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_idx,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic [DATA_W-1:0] sw_rdata,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_idx,
   input  logic [DATA_W-1:0] eng_wdata,
   output logic [DATA_W-1:0] eng_rdata
);
   logic [DEPTH-1:0][DATA_W-1:0] mem;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      logic              hit_eng, hit_sw;
      assign hit_eng = eng_we && (eng_idx == IDX_W'(e));
      assign hit_sw  = sw_we  && (sw_idx  == IDX_W'(e));
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ent_q <= '0;
            else if (hit_eng) ent_q <= eng_wdata;
            else if (hit_sw)  ent_q <= sw_wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit_eng)     ent_q <= eng_wdata;
            else if (hit_sw) ent_q <= sw_wdata;
         end
      end
      assign mem[e] = ent_q;
   end

   assign sw_rdata  = mem[sw_idx];
   assign eng_rdata = mem[eng_idx];
endmodule

// File: rtl/smbb_seq.sv
module smbb_seq #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MAX_LEN = 32,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned P_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_rd,
   input  logic              bufen_in,
   input  logic [DATA_W-1:0] cnt,
   input  logic              last_sel,
   input  logic              bd_flag,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              tx_take,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              rx_ready,
   output logic              eng_last,
   output logic              busy,
   output logic              ev_done,
   output logic              ev_fail,
   output logic              ev_byte,
   output logic              cnt_we,
   output logic              ram_we,
   output logic              hold_we,
   output logic [IDX_W-1:0]  eng_idx
);
   logic           active_q, dir_q, mode_q;
   logic [P_W-1:0] pos_q;
   logic           stall, tx_fire, rx_fire, fire, cnt_phase;
   logic           len_bad, cnt_bad, at_count, finish, start_ok;

   assign stall     = !mode_q && bd_flag;
   assign tx_valid  = active_q && !dir_q && !stall;
   assign rx_ready  = active_q &&  dir_q && !stall;
   assign tx_fire   = tx_valid && tx_take;
   assign rx_fire   = rx_ready && rx_valid;
   assign fire      = tx_fire || rx_fire;
   assign cnt_phase = (pos_q == '0);
   assign len_bad   = (rx_data == '0) || (rx_data > DATA_W'(MAX_LEN));
   assign cnt_bad   = (cnt == '0) || (cnt > DATA_W'(MAX_LEN));
   assign at_count  = (DATA_W'(pos_q) == cnt);
   assign finish    = mode_q ? at_count : (dir_q ? last_sel : at_count);
   assign start_ok  = start && !active_q;
   assign eng_idx   = IDX_W'(pos_q - P_W'(1));
   assign tx_data   = cnt_phase ? cnt : (mode_q ? ram_rdata : hold_q);
   assign eng_last  = active_q && dir_q && !cnt_phase && (mode_q ? at_count : last_sel);
   assign busy      = active_q;

   assign ev_fail = (start_ok && !dir_rd && cnt_bad) || (rx_fire && cnt_phase && len_bad);
   assign cnt_we  = rx_fire && cnt_phase && !len_bad;
   assign ram_we  = rx_fire && !cnt_phase && mode_q;
   assign hold_we = rx_fire && !cnt_phase && !mode_q;
   assign ev_byte = fire && !cnt_phase && !mode_q;
   assign ev_done = fire && !cnt_phase && finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         dir_q    <= 1'b0;
         mode_q   <= 1'b0;
         pos_q    <= '0;
      end else if (start_ok) begin
         active_q <= dir_rd || !cnt_bad;
         dir_q    <= dir_rd;
         mode_q   <= bufen_in;
         pos_q    <= '0;
      end else if (fire) begin
         if (cnt_phase && rx_fire && len_bad) active_q <= 1'b0;
         else if (!cnt_phase && finish)       active_q <= 1'b0;
         else                                 pos_q    <= pos_q + P_W'(1);
      end
   end

   // R7
   bd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !mode_q && !cnt_phase) |=> !(tx_valid || rx_ready));
   // R6
   bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fire && cnt_phase && len_bad) |=> !active_q);
   // R4
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_take) |=> $stable(pos_q));
endmodule

// File: rtl/smbb_regs.sv
module smbb_regs
   import smbb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              wr,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ev_done,
   input  logic              ev_fail,
   input  logic              ev_byte,
   input  logic              busy,
   input  logic              cnt_we,
   input  logic              hold_we,
   input  logic [DATA_W-1:0] eng_byte,
   input  logic [DATA_W-1:0] sw_rdata,
   output logic [DATA_W-1:0] cnt_q,
   output logic              last_q,
   output logic              bufen_q,
   output logic              bd_q,
   output logic [DATA_W-1:0] hold_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic              sw_we
);
   logic st_done_q, st_fail_q;
   logic ctl_rd, port_acc, stat_wr;
   logic [DATA_W-1:0] stat_v, ctrl_v, aux_v;

   assign ctl_rd   = rd && (addr == RA_CTRL);
   assign port_acc = (rd || wr) && (addr == RA_PORT);
   assign stat_wr  = wr && (addr == RA_STAT);
   assign sw_we    = wr && (addr == RA_PORT) && bufen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bd_q      <= 1'b0;
         st_fail_q <= 1'b0;
         st_done_q <= 1'b0;
      end else begin
         bd_q      <= ev_byte || (bd_q      && !(stat_wr && wdata[ST_BDONE]));
         st_fail_q <= ev_fail || (st_fail_q && !(stat_wr && wdata[ST_FAIL]));
         st_done_q <= ev_done || (st_done_q && !(stat_wr && wdata[ST_DONE]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= 1'b0;
         bufen_q <= 1'b0;
         cnt_q   <= '0;
         hold_q  <= '0;
         idx_q   <= '0;
      end else begin
         if (wr && addr == RA_CTRL) last_q  <= wdata[CTL_LAST];
         if (wr && addr == RA_AUX)  bufen_q <= wdata[AUX_BUFEN];
         if (cnt_we)                       cnt_q <= eng_byte;
         else if (wr && addr == RA_CNT)    cnt_q <= wdata;
         if (hold_we)                            hold_q <= eng_byte;
         else if (wr && addr == RA_PORT && !bufen_q) hold_q <= wdata;
         if (ctl_rd)        idx_q <= '0;
         else if (port_acc) idx_q <= idx_q + IDX_W'(1);
      end
   end

   always_comb begin
      stat_v = '0;
      stat_v[ST_BDONE] = bd_q;
      stat_v[ST_FAIL]  = st_fail_q;
      stat_v[ST_DONE]  = st_done_q;
      stat_v[ST_BUSY]  = busy;
      ctrl_v = '0;
      ctrl_v[CTL_LAST] = last_q;
      aux_v = '0;
      aux_v[AUX_BUFEN] = bufen_q;
      case (addr)
         RA_STAT: rdata = stat_v;
         RA_CTRL: rdata = ctrl_v;
         RA_CNT:  rdata = cnt_q;
         RA_PORT: rdata = bufen_q ? sw_rdata : hold_q;
         RA_AUX:  rdata = aux_v;
         default: rdata = '0;
      endcase
   end

   // R3
   ctl_rd_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |=> (idx_q == '0));
   // R2
   port_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_acc && !ctl_rd) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
   // R10
   done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |=> st_done_q);
   // R7
   bd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte |=> bd_q);
endmodule

// File: rtl/smbb_block_buf.sv
module smbb_block_buf #(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned DEPTH          = 32,
   parameter int unsigned MAX_LEN        = 32,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              eng_start,
   input  logic              eng_dir_rd,
   output logic              eng_tx_valid,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_tx_take,
   input  logic              eng_rx_valid,
   input  logic [DATA_W-1:0] eng_rx_data,
   output logic              eng_rx_ready,
   output logic              eng_last
);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned P_W   = $clog2(MAX_LEN + 1);

   if (MAX_LEN > DEPTH) begin : g_len_chk
      $error("MAX_LEN must not exceed DEPTH");
   end
   if (DEPTH != (1 << IDX_W)) begin : g_pow_chk
      $error("DEPTH must be a power of two");
   end
   if (DATA_W < 8) begin : g_w_chk
      $error("DATA_W must be at least 8");
   end
   if (MAX_LEN >= (1 << DATA_W)) begin : g_cnt_chk
      $error("MAX_LEN must fit in one count byte");
   end

   logic [DATA_W-1:0] cnt_q, hold_q, sw_rdata, ram_rdata;
   logic [IDX_W-1:0]  idx_q, eng_idx;
   logic last_q, bufen_q, bd_q, busy, sw_we;
   logic ev_done, ev_fail, ev_byte, cnt_we, ram_we, hold_we;

   smbb_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .ev_done(ev_done), .ev_fail(ev_fail),
      .ev_byte(ev_byte), .busy(busy), .cnt_we(cnt_we), .hold_we(hold_we),
      .eng_byte(eng_rx_data), .sw_rdata(sw_rdata), .cnt_q(cnt_q), .last_q(last_q),
      .bufen_q(bufen_q), .bd_q(bd_q), .hold_q(hold_q), .idx_q(idx_q), .sw_we(sw_we)
   );

   smbb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_idx(idx_q), .sw_wdata(reg_wdata),
      .sw_rdata(sw_rdata), .eng_we(ram_we), .eng_idx(eng_idx),
      .eng_wdata(eng_rx_data), .eng_rdata(ram_rdata)
   );

   smbb_seq #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .P_W(P_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .dir_rd(eng_dir_rd),
      .bufen_in(bufen_q), .cnt(cnt_q), .last_sel(last_q), .bd_flag(bd_q),
      .ram_rdata(ram_rdata), .hold_q(hold_q), .tx_take(eng_tx_take),
      .rx_valid(eng_rx_valid), .rx_data(eng_rx_data), .tx_valid(eng_tx_valid),
      .tx_data(eng_tx_data), .rx_ready(eng_rx_ready), .eng_last(eng_last),
      .busy(busy), .ev_done(ev_done), .ev_fail(ev_fail), .ev_byte(ev_byte),
      .cnt_we(cnt_we), .ram_we(ram_we), .hold_we(hold_we), .eng_idx(eng_idx)
   );
endmodule

// File: tb/sim_smbb_block_buf.sv
module sim_smbb_block_buf;
   localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2,
                          A_PORT = 3'd3, A_AUX = 3'd4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_rd = 1'b0, reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic eng_start = 1'b0, eng_dir_rd = 1'b0, eng_tx_take = 1'b0;
   logic eng_rx_valid = 1'b0;
   logic [7:0] eng_rx_data = '0;
   logic eng_tx_valid, eng_rx_ready, eng_last;
   logic [7:0] eng_tx_data;

   int tests = 0, fails = 0;
   logic [7:0] exp_tx[$];
   string tx_tag = "R4";

   always #10 clk = ~clk;

   smbb_block_buf u0 (
      .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_start(eng_start), .eng_dir_rd(eng_dir_rd), .eng_tx_valid(eng_tx_valid),
      .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
      .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
      .eng_rx_ready(eng_rx_ready), .eng_last(eng_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // stream model: every taken byte must match the queue front
   always @(negedge clk) begin
      if (rst_n && eng_tx_valid && eng_tx_take) begin
         if (exp_tx.size() == 0) chk(1'b0, tx_tag, int'(eng_tx_data), -1);
         else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(eng_tx_data == e, tx_tag, int'(eng_tx_data), int'(e));
         end
      end
   end

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      @(posedge clk); #1 reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); d = reg_rdata;
      @(posedge clk); #1 reg_rd = 1'b0;
   endtask

   task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
      logic [7:0] v;
      reg_read(a, v);
      chk(v == e, req, int'(v), int'(e));
   endtask

   task automatic start_xfer(input logic rd);
      @(posedge clk); #1 eng_start = 1'b1; eng_dir_rd = rd;
      @(posedge clk); #1 eng_start = 1'b0;
   endtask

   task automatic rx_send(input logic [7:0] b, output logic l);
      @(posedge clk); #1 eng_rx_valid = 1'b1; eng_rx_data = b;
      @(negedge clk);
      while (!eng_rx_ready) @(negedge clk);
      l = eng_last;
      @(posedge clk); #1 eng_rx_valid = 1'b0;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic l;
      logic [7:0] wr_pay [3] = '{8'hA1, 8'hB2, 8'hC3};
      logic [7:0] rd_pay [4] = '{8'h11, 8'h22, 8'h33, 8'h44};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk(!eng_tx_valid && !eng_rx_ready && !eng_last, "R1",
          int'({eng_tx_valid, eng_rx_ready, eng_last}), 0);
      for (int a = 0; a < 5; a++) expect_reg(3'(a), 8'h00, "R1");

      // R2 / R3 buffer fill and readback
      reg_write(A_AUX, 8'h02);
      reg_write(A_CNT, 8'd3);
      reg_read(A_CTRL, v);
      for (int i = 0; i < 3; i++) reg_write(A_PORT, wr_pay[i]);
      reg_read(A_CTRL, v);
      for (int i = 0; i < 3; i++) expect_reg(A_PORT, wr_pay[i], "R3");
      expect_reg(A_PORT, 8'h00, "R2");

      // R4 buffer-mode write
      tx_tag = "R4";
      exp_tx.push_back(8'd3);
      for (int i = 0; i < 3; i++) exp_tx.push_back(wr_pay[i]);
      #1 eng_tx_take = 1'b1;
      start_xfer(1'b0);
      repeat (8) @(posedge clk);
      #1 eng_tx_take = 1'b0;
      chk(exp_tx.size() == 0, "R4", exp_tx.size(), 0);
      expect_reg(A_STAT, 8'h02, "R4");
      reg_write(A_STAT, 8'hFF);

      // R5 / R11 buffer-mode read
      start_xfer(1'b1);
      rx_send(8'd4, l);
      chk(l == 1'b0, "R11", int'(l), 0);
      for (int i = 0; i < 4; i++) begin
         rx_send(rd_pay[i], l);
         chk(l == (i == 3), "R11", int'(l), int'(i == 3));
      end
      @(negedge clk);
      chk(!eng_rx_ready, "R5", int'(eng_rx_ready), 0);
      expect_reg(A_STAT, 8'h02, "R5");
      expect_reg(A_CNT, 8'd4, "R5");
      reg_read(A_CTRL, v);
      for (int i = 0; i < 4; i++) expect_reg(A_PORT, rd_pay[i], "R5");
      reg_write(A_STAT, 8'hFF);

      // R5 boundary: count of 32
      start_xfer(1'b1);
      rx_send(8'd32, l);
      for (int i = 0; i < 32; i++) rx_send(8'(i * 3 + 1), l);
      chk(l == 1'b1, "R11", int'(l), 1);
      expect_reg(A_STAT, 8'h02, "R5");
      reg_read(A_CTRL, v);
      for (int i = 0; i < 32; i += 31) begin
         reg_read(A_CTRL, v);
         for (int k = 0; k < i; k++) reg_read(A_PORT, v);
         expect_reg(A_PORT, 8'(i * 3 + 1), "R5");
      end
      reg_write(A_STAT, 8'hFF);

      // R6 bad received counts
      start_xfer(1'b1);
      rx_send(8'd0, l);
      @(negedge clk);
      chk(!eng_rx_ready, "R6", int'(eng_rx_ready), 0);
      expect_reg(A_STAT, 8'h10, "R6");
      reg_write(A_STAT, 8'hFF);
      start_xfer(1'b1);
      rx_send(8'd33, l);
      @(negedge clk);
      chk(!eng_rx_ready, "R6", int'(eng_rx_ready), 0);
      expect_reg(A_STAT, 8'h10, "R6");
      reg_write(A_STAT, 8'hFF);
      // R6 bad loaded count on write
      reg_write(A_CNT, 8'd0);
      #1 eng_tx_take = 1'b1;
      start_xfer(1'b0);
      @(negedge clk);
      chk(!eng_tx_valid, "R6", int'(eng_tx_valid), 0);
      expect_reg(A_STAT, 8'h10, "R6");
      #1 eng_tx_take = 1'b0;
      reg_write(A_STAT, 8'hFF);

      // R7 / R8 byte-mode write
      tx_tag = "R8";
      reg_write(A_AUX, 8'h00);
      reg_write(A_CNT, 8'd2);
      reg_write(A_PORT, 8'h61);
      exp_tx.push_back(8'd2);
      exp_tx.push_back(8'h61);
      #1 eng_tx_take = 1'b1;
      start_xfer(1'b0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!eng_tx_valid, "R7", int'(eng_tx_valid), 0);
      expect_reg(A_STAT, 8'h81, "R7");
      exp_tx.push_back(8'h62);
      reg_write(A_PORT, 8'h62);
      reg_write(A_STAT, 8'h80);
      repeat (4) @(posedge clk);
      expect_reg(A_STAT, 8'h82, "R8");
      chk(exp_tx.size() == 0, "R8", exp_tx.size(), 0);
      #1 eng_tx_take = 1'b0;
      reg_write(A_STAT, 8'hFF);

      // R7 / R8 / R9 byte-mode read
      reg_write(A_CTRL, 8'h00);
      start_xfer(1'b1);
      rx_send(8'd2, l);
      rx_send(8'h71, l);
      chk(l == 1'b0, "R9", int'(l), 0);
      @(negedge clk);
      chk(!eng_rx_ready, "R7", int'(eng_rx_ready), 0);
      expect_reg(A_STAT, 8'h81, "R7");
      expect_reg(A_PORT, 8'h71, "R8");
      reg_write(A_CTRL, 8'h01);
      @(negedge clk);
      chk(eng_last, "R9", int'(eng_last), 1);
      reg_write(A_STAT, 8'h80);
      rx_send(8'h72, l);
      chk(l == 1'b1, "R9", int'(l), 1);
      expect_reg(A_STAT, 8'h82, "R9");
      expect_reg(A_PORT, 8'h72, "R8");
      reg_write(A_STAT, 8'hFF);
      reg_write(A_CTRL, 8'h00);

      // R10 clear colliding with set
      tx_tag = "R10";
      reg_write(A_AUX, 8'h02);
      reg_write(A_CNT, 8'd1);
      reg_read(A_CTRL, v);
      reg_write(A_PORT, 8'h5A);
      exp_tx.push_back(8'd1); exp_tx.push_back(8'h5A);
      exp_tx.push_back(8'd1); exp_tx.push_back(8'h5A);
      #1 eng_tx_take = 1'b1;
      start_xfer(1'b0);
      repeat (4) @(posedge clk);
      #1 eng_tx_take = 1'b0;
      expect_reg(A_STAT, 8'h02, "R10");
      start_xfer(1'b0);
      @(posedge clk); #1 eng_tx_take = 1'b1;
      @(posedge clk); #1 reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 8'h02;
      @(posedge clk); #1 reg_wr = 1'b0; eng_tx_take = 1'b0;
      expect_reg(A_STAT, 8'h02, "R10");
      chk(exp_tx.size() == 0, "R10", exp_tx.size(), 0);
      reg_write(A_STAT, 8'h02);
      expect_reg(A_STAT, 8'h00, "R10");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule